// File: doc/BRIEF.md
# Prescaled Event Timer/Counter

This block is an 8-bit count register that steps on one of two sources. The first is a one-cycle tick from the core's instruction-cycle timing. The second is a chosen edge of an asynchronous input pin, which passes through a synchronizer before it is counted. A power-of-two prescaler can be placed in front of the counter, or left out so that every source tick reaches the counter directly. The prescaler's running count is reset only when software writes the count register.

The register file reads and writes the count like any other general register. A sticky wrap flag goes to an interrupt controller. That controller acknowledges the flag with a one-cycle clear strobe.

Top module: `evt_timer8`

## Requirements
- R1: While reset is asserted and right after it, `cnt_rd` reads 0x00, `wrap_flag` reads 0 and the prescaler's running count is zero.
- R2: With `use_pin`=0 and `pre_off`=1, each cycle in which `cyc_tick` is high advances `cnt_rd` by exactly one at that clock edge. Cycles with `cyc_tick` low leave it unchanged.
- R3: With `use_pin`=1 and `fall_edge`=0, every rising transition of `ext_pin` adds exactly one count, and `cyc_tick` is ignored. A pin level that is stable before clock edge k is reflected in `cnt_rd` after edge k+2.
- R4: With `use_pin`=1 and `fall_edge`=1, only falling transitions of `ext_pin` are counted, with the same latency as R3.
- R5: With `pre_off`=0, the counter advances once per 2^(`pre_div`+1) source ticks, so `pre_div` values 0 through 7 give division by 2 through 256. The first advance comes on the 2^(`pre_div`+1)-th tick after a reset or a count write.
- R6: A cycle with `cnt_we`=1 loads `cnt_wdata` into the count, and the value is visible on `cnt_rd` after that edge. If an increment falls in the same cycle, the written value wins and the increment is lost.
- R7: A count write is the only event that clears the prescaler's running count. Changing `pre_off` or `pre_div` leaves the partial count in place, and while `pre_off`=1 the prescaler does not move.
- R8: An increment from 0xFF to 0x00 sets `wrap_flag`, and the flag stays set until a cycle with `wrap_clr`=1. If a wrap and the clear strobe arrive in the same cycle, the flag ends up set. A write never sets the flag.
- R9: A pin held at one level for any number of cycles produces no counts beyond its single transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count input |
| use_pin | input | 1 | Source select: 1 = pin edge, 0 = cycle tick |
| fall_edge | input | 1 | Pin edge select: 1 = falling, 0 = rising |
| pre_off | input | 1 | 1 = prescaler not assigned, source clocks the counter directly |
| pre_div | input | 3 | Prescale exponent; ratio is 2^(pre_div+1) |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count register write data |
| cnt_rd | output | 8 | Count register read value |
| wrap_clr | input | 1 | Clear strobe for the wrap flag |
| wrap_flag | output | 1 | Sticky wrap flag toward the interrupt controller |

## Verification
A wrong count value appears on `cnt_rd` at the very next clock edge, because the bench compares that register against its model in every cycle. A corrupted prescaler count stays hidden until the next division boundary, which is up to 256 source ticks later. For that reason the bench runs partial divisions across bypass toggles and count writes, then checks exactly when the following advance lands. A synchronizer or edge-detector fault shows up as a missing count, a doubled count, or a count one cycle early or late. A flag fault shows up at the wrap cycle or at the clear strobe.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;
  // Static configuration as seen by the counting path
  typedef struct packed {
    logic use_pin;    // count pin edges instead of cycle ticks
    logic fall_edge;  // pin edge polarity
    logic pre_off;    // prescaler bypassed
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              rise_w;
  logic              fall_w;

  // Synchronizer chain, one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  // History flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_w = chain_q[STAGES-1] & ~last_q;
  assign fall_w = ~chain_q[STAGES-1] & last_q;
  assign edge_o = fall_sel_i ? fall_w : rise_w;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> !rise_w); // R9
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> !fall_w); // R9
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             off_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             fire_o
);
  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic             advance_w;
  logic [PRE_W-1:0] mask_w;

  // Low sel+1 bits set: the divide boundary is reached when they are all ones
  function automatic logic [PRE_W-1:0] ratio_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i <= int'(sel));
    return m;
  endfunction

  assign advance_w = tick_i & ~off_i;
  assign mask_w    = ratio_mask(sel_i);
  assign fire_o    = advance_w & ((pre_q & mask_w) == mask_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (clr_i)     pre_q <= '0;
    else if (advance_w) pre_q <= pre_q + 1'b1;
  end

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pre_q == '0)); // R7
  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !advance_w) |=> $stable(pre_q)); // R7
  AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && advance_w) |=> (pre_q == $past(pre_q) + 1'b1)); // R5
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             step_w;
  logic             wrap_w;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  assign step_w = inc_i & ~we_i;
  assign wrap_w = step_w & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (we_i)   cnt_q <= wdata_i;
    else if (step_w) cnt_q <= next_count(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (wrap_w)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cnt_q == $past(wdata_i))); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && inc_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !inc_i) |=> $stable(cnt_q)); // R2
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && inc_i && cnt_q == TOP) |=> flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q); // R8
  AST_FLAG_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && we_i) |=> !flag_q); // R8
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             ext_pin,
  input  logic             use_pin,
  input  logic             fall_edge,
  input  logic             pre_off,
  input  logic [SEL_W-1:0] pre_div,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rd,
  input  logic             wrap_clr,
  output logic             wrap_flag
);
  tmr_cfg_t cfg_w;
  logic     pin_edge_w;
  logic     src_tick_w;
  logic     pre_fire_w;
  logic     cnt_inc_w;

  assign cfg_w = '{use_pin: use_pin, fall_edge: fall_edge, pre_off: pre_off};

  tmr_pin_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin),
    .fall_sel_i (cfg_w.fall_edge),
    .edge_o     (pin_edge_w)
  );

  assign src_tick_w = cfg_w.use_pin ? pin_edge_w : cyc_tick;

  tmr_prescaler #(.SEL_W(SEL_W)) i_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (src_tick_w),
    .off_i  (cfg_w.pre_off),
    .sel_i  (pre_div),
    .clr_i  (cnt_we),
    .fire_o (pre_fire_w)
  );

  assign cnt_inc_w = cfg_w.pre_off ? src_tick_w : pre_fire_w;

  tmr_count_reg #(.CNT_W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (cnt_inc_w),
    .we_i       (cnt_we),
    .wdata_i    (cnt_wdata),
    .flag_clr_i (wrap_clr),
    .cnt_o      (cnt_rd),
    .flag_o     (wrap_flag)
  );

  AST_PIN_MODE_IGNORES_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    (use_pin && pre_off && !pin_edge_w && !cnt_we) |=> $stable(cnt_rd)); // R3
  AST_BYPASS_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_off && !src_tick_w && !cnt_we) |=> $stable(cnt_rd)); // R2
endmodule

// File: tb/test_evt_timer8.sv
`timescale 1ns/1ps
module test_evt_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0, ext_pin = 1'b0, use_pin = 1'b0, fall_edge = 1'b0;
  logic       pre_off = 1'b1, cnt_we = 1'b0, wrap_clr = 1'b0;
  logic [2:0] pre_div = 3'd0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt_rd;
  logic       wrap_flag;

  int    n_checks = 0;
  int    n_fail = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  evt_timer8 i_evt_timer8 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .use_pin(use_pin), .fall_edge(fall_edge), .pre_off(pre_off),
    .pre_div(pre_div), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_rd(cnt_rd), .wrap_clr(wrap_clr), .wrap_flag(wrap_flag)
  );

  // Behavioural reference model
  int m_cnt = 0, m_pre = 0;
  bit m_flag = 0;
  int pin_hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit src, fire, inc, wrap;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_flag = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      if (use_pin)
        src = fall_edge ? (pin_hist[0] == 1 && pin_hist[1] == 0)
                        : (pin_hist[0] == 0 && pin_hist[1] == 1);
      else
        src = cyc_tick;
      fire = 0;
      if (cnt_we) m_pre = 0;
      else if (!pre_off && src) begin
        m_pre = (m_pre + 1) % 256;
        fire  = (m_pre % (2 ** (pre_div + 1))) == 0;
      end
      inc  = pre_off ? src : fire;
      wrap = 0;
      if (cnt_we) m_cnt = cnt_wdata;
      else if (inc) begin
        wrap  = (m_cnt == 255);
        m_cnt = (m_cnt + 1) % 256;
      end
      if (wrap) m_flag = 1;
      else if (wrap_clr) m_flag = 0;
      pin_hist.push_back(int'(ext_pin));
      void'(pin_hist.pop_front());
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Comparison against the model on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check({phase, " count"}, int'(cnt_rd), m_cnt);
      check({phase, " flag"}, int'(wrap_flag), int'(m_flag));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cnt(logic [7:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); cyc_tick = 1'b1;
    cyc(n);
    cyc_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 reset count", int'(cnt_rd), 0);
    check("R1 reset flag", int'(wrap_flag), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 after reset", int'(cnt_rd), 0);

    // R2: direct cycle ticks, sparse then dense
    phase = "R2";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); cyc_tick = (i % 2 == 0);
    end
    @(negedge clk); cyc_tick = 1'b0;
    cyc(1);
    check("R2 sparse ticks", int'(cnt_rd), 5);
    ticks(7);
    cyc(1);
    check("R2 dense ticks", int'(cnt_rd), 12);

    // R6: write collides with increment
    phase = "R6";
    @(negedge clk); cyc_tick = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'h40;
    @(negedge clk); cyc_tick = 1'b0; cnt_we = 1'b0;
    check("R6 write wins", int'(cnt_rd), 8'h40);

    // R3: rising pin edges, cycle tick active but ignored
    phase = "R3";
    use_pin = 1'b1; fall_edge = 1'b0; cyc_tick = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1'b1; cyc(3 + i % 2);
      ext_pin = 1'b0; cyc(3);
    end
    cyc(4);
    check("R3 rising edges", int'(cnt_rd), 8'h45);
    // latency: pin stable before edge k, count after edge k+2
    ext_pin = 1'b1;
    cyc(2);
    check("R3 not yet", int'(cnt_rd), 8'h45);
    cyc(1);
    check("R3 latency", int'(cnt_rd), 8'h46);

    // R9: held level gives a single count
    phase = "R9";
    cyc(20);
    check("R9 held high", int'(cnt_rd), 8'h46);
    ext_pin = 1'b0; cyc(20);
    check("R9 held low", int'(cnt_rd), 8'h46);

    // R4: falling edges
    phase = "R4";
    fall_edge = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ext_pin = 1'b1; cyc(4);
      ext_pin = 1'b0; cyc(3);
    end
    cyc(4);
    check("R4 falling edges", int'(cnt_rd), 8'h4A);
    use_pin = 1'b0; fall_edge = 1'b0; cyc_tick = 1'b0;

    // R5: prescale ratios
    phase = "R5";
    pre_off = 1'b0;
    pre_div = 3'd0; write_cnt(8'h00); ticks(10); cyc(2);
    check("R5 div2", int'(cnt_rd), 5);
    pre_div = 3'd2; write_cnt(8'h00); ticks(7); cyc(1);
    check("R5 div8 before boundary", int'(cnt_rd), 0);
    ticks(13); cyc(2);
    check("R5 div8", int'(cnt_rd), 2);
    pre_div = 3'd7; write_cnt(8'h00); ticks(255); cyc(1);
    check("R5 div256 before boundary", int'(cnt_rd), 0);
    ticks(45); cyc(2);
    check("R5 div256", int'(cnt_rd), 1);

    // R7: prescaler survives bypass and select changes, cleared by write
    phase = "R7";
    pre_div = 3'd1; write_cnt(8'h00); ticks(2);
    pre_off = 1'b1; pre_div = 3'd3; ticks(3);
    check("R7 bypass counts direct", int'(cnt_rd), 3);
    pre_off = 1'b0; pre_div = 3'd1; ticks(2); cyc(1);
    check("R7 partial count kept", int'(cnt_rd), 4);
    ticks(3); write_cnt(8'h10); ticks(1); cyc(1);
    check("R7 write cleared prescaler", int'(cnt_rd), 8'h10);
    ticks(3); cyc(1);
    check("R7 next boundary", int'(cnt_rd), 8'h11);

    // R8: wrap flag
    phase = "R8";
    pre_off = 1'b1;
    write_cnt(8'hFE); ticks(1); cyc(1);
    check("R8 no flag at FF", int'(wrap_flag), 0);
    ticks(1); cyc(1);
    check("R8 wrap count", int'(cnt_rd), 0);
    check("R8 flag set", int'(wrap_flag), 1);
    ticks(3); cyc(1);
    check("R8 flag sticky", int'(wrap_flag), 1);
    @(negedge clk); wrap_clr = 1'b1;
    @(negedge clk); wrap_clr = 1'b0;
    check("R8 flag cleared", int'(wrap_flag), 0);
    write_cnt(8'hFF);
    @(negedge clk); cyc_tick = 1'b1; wrap_clr = 1'b1;
    @(negedge clk); cyc_tick = 1'b0; wrap_clr = 1'b0;
    check("R8 set beats clear", int'(wrap_flag), 1);
    @(negedge clk); wrap_clr = 1'b1;
    @(negedge clk); wrap_clr = 1'b0;
    write_cnt(8'hFF);
    @(negedge clk); cyc_tick = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'h00;
    @(negedge clk); cyc_tick = 1'b0; cnt_we = 1'b0;
    check("R8 write no flag", int'(wrap_flag), 0);
    check("R6 write over wrap", int'(cnt_rd), 0);

    // R1: reset again mid-run
    phase = "R1";
    ticks(5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 second reset", int'(cnt_rd), 0);
    rst_n = 1'b1;
    cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule